// File: doc/BRIEF.md
# Interlocked Half-Bridge Gate Command Logic

This block turns two logic commands, one for the high-side switch and one for the low-side switch of a half bridge, into two gate-enable outputs. Every input is asynchronous and passes through a two-flop synchronizer. After that, three rules act on the commands. A global active-low shutdown forces both outputs off. An interlock keeps both outputs off whenever both commands are asserted. A per-side supply-good flag gates each output.

The two channels are treated differently. The high-side command is stretched so that each of its levels, on or off, lasts at least a minimum number of clock cycles. The low-side command gets no stretching. It passes through a fixed delay line so that its propagation matches the high-side path, which also has to cross an isolation link. Both outputs are registered.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While the synchronized shutdown input `sd_ni` is 0, both outputs are 0 whatever the commands are. Shutdown takes effect on the 3rd rising edge after `sd_ni` falls.
- R2: With `cmd_hi_i`=1, `cmd_lo_i`=0, shutdown released and both supplies good, only `gate_hi_o` turns on. It does so on the 4th rising edge after the command is presented, provided the stretch counter is idle.
- R3: While both commands are 1, both outputs are 0. When one command returns to 0, the other channel's output resumes.
- R4: Each level of the stretched high-side command lasts at least `MIN_ON_CYC` cycles (default 5), for on pulses and for off gaps alike. Levels held for `MIN_ON_CYC` cycles or longer keep their length.
- R5: The low-side path does no stretching: a 1-cycle low-side command pulse gives a 1-cycle `gate_lo_o` pulse.
- R6: `gate_lo_o` turns on at the (`LO_DLY_CYC`+3)th rising edge after `cmd_lo_i` rises (default 5th).
- R7: `gate_hi_o` is 0 while the synchronized `uv_ok_hi_i` is 0, and `gate_lo_o` is 0 while the synchronized `uv_ok_lo_i` is 0. Each flag acts on its own side only.
- R8: While `rst_ni` is 0, both outputs are 0 and the stretch and delay state is cleared.
- R9: `gate_hi_o` and `gate_lo_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_hi_i | input | 1 | High-side command, asynchronous |
| cmd_lo_i | input | 1 | Low-side command, asynchronous |
| sd_ni | input | 1 | Shutdown, active low, asynchronous |
| uv_ok_hi_i | input | 1 | High-side supply above on threshold |
| uv_ok_lo_i | input | 1 | Low-side supply above on threshold |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |

## Verification
The assertions assume that only the synchronized copies of the inputs matter, so input changes may fall on any cycle. They also assume that a supply flag is a plain level, with any hysteresis handled upstream. The random stimulus changes commands and flags only at the falling clock edge. It biases the commands toward pulses both shorter and longer than the stretch width, and keeps shutdown and supply dropouts rare, so that both the interlock and the gating are visited often. Directed cases add single-cycle pulses and gaps, overlapping commands and latency measurements taken from an idle state.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic cmd_hi;
    logic cmd_lo;
    logic sd_n;
    logic uv_hi;
    logic uv_lo;
  } hb_in_t;
  localparam int unsigned HB_IN_W = $bits(hb_in_t);
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_stretch.sv
module hb_stretch #(
  parameter int unsigned MIN_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] hold_q;
  logic          lvl_q;

  // every accepted edge starts a hold window covering the rest of the level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      lvl_q  <= 1'b0;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else if (d_i != lvl_q) begin
      lvl_q  <= d_i;
      hold_q <= CW'(MIN_CYC - 1);
    end
  end

  assign q_o = lvl_q;

  logic [CW-1:0] run_q;
  logic          prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= CW'(MIN_CYC);
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl_q;
      if (lvl_q != prev_q) run_q <= CW'(1);
      else if (run_q != CW'(MIN_CYC)) run_q <= run_q + 1'b1;
    end
  end

  assert_min_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != prev_q) |-> (run_q >= CW'(MIN_CYC)));
endmodule

// File: rtl/hb_delay.sv
module hb_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (DLY == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_line
    logic [DLY-1:0] tap_q;
    for (genvar k = 0; k < DLY; k++) begin : g_tap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tap_q[k] <= 1'b0;
        else if (k == 0) tap_q[k] <= d_i;
        else tap_q[k] <= tap_q[(k == 0) ? 0 : k-1];
      end
    end
    assign q_o = tap_q[DLY-1];
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned MIN_ON_CYC  = 5,
  parameter int unsigned LO_DLY_CYC  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_hi_i,
  input  logic cmd_lo_i,
  input  logic sd_ni,
  input  logic uv_ok_hi_i,
  input  logic uv_ok_lo_i,
  output logic gate_hi_o,
  output logic gate_lo_o
);
  hb_in_t raw, syn;
  logic   hi_str, lo_dly;
  logic   gate_hi_q, gate_lo_q;

  assign raw = '{cmd_hi: cmd_hi_i, cmd_lo: cmd_lo_i, sd_n: sd_ni,
                 uv_hi: uv_ok_hi_i, uv_lo: uv_ok_lo_i};

  hb_sync #(.W(HB_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  hb_stretch #(.MIN_CYC(MIN_ON_CYC)) u_stretch (
    .clk_i, .rst_ni, .d_i(syn.cmd_hi), .q_o(hi_str)
  );

  hb_delay #(.DLY(LO_DLY_CYC)) u_lo_dly (
    .clk_i, .rst_ni, .d_i(syn.cmd_lo), .q_o(lo_dly)
  );

  // interlock after stretch and delay: aligned views of both channels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_hi_q <= 1'b0;
      gate_lo_q <= 1'b0;
    end else begin
      gate_hi_q <= syn.sd_n & syn.uv_hi & hi_str & ~lo_dly;
      gate_lo_q <= syn.sd_n & syn.uv_lo & lo_dly & ~hi_str;
    end
  end

  assign gate_hi_o = gate_hi_q;
  assign gate_lo_o = gate_lo_q;

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_o && gate_lo_o));
  assert_shutdown_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.sd_n |=> (!gate_hi_o && !gate_lo_o));
  assert_uv_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.uv_hi |=> !gate_hi_o);
  assert_uv_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.uv_lo |=> !gate_lo_o);
  assert_both_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_str && lo_dly) |=> (!gate_hi_o && !gate_lo_o));
endmodule

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;
  localparam int MINW = 5;
  localparam int LDLY = 2;

  logic clk = 0, rst_n = 0;
  logic c_hi = 0, c_lo = 0, sd_n = 1, uvh = 1, uvl = 1;
  logic g_hi, g_lo;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hb_gate_ctrl #(.MIN_ON_CYC(MINW), .LO_DLY_CYC(LDLY), .SYNC_STAGES(2)) u_hb_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_hi_i(c_hi), .cmd_lo_i(c_lo), .sd_ni(sd_n),
    .uv_ok_hi_i(uvh), .uv_ok_lo_i(uvl), .gate_hi_o(g_hi), .gate_lo_o(g_lo)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  logic [4:0] m_s1, m_s2;
  logic       m_h, m_gh, m_gl;
  int         m_cnt;
  logic [LDLY-1:0] m_dl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_h <= 0; m_cnt <= 0; m_dl <= '0; m_gh <= 0; m_gl <= 0;
    end else begin
      m_s1 <= {c_hi, c_lo, sd_n, uvh, uvl};
      m_s2 <= m_s1;
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
      else if (m_s2[4] != m_h) begin m_h <= m_s2[4]; m_cnt <= MINW - 1; end
      m_dl <= {m_dl[LDLY-1:0], m_s2[3]} >> 0;
      m_gh <= m_s2[2] & m_s2[1] & m_h & ~m_dl[LDLY-1];
      m_gl <= m_s2[2] & m_s2[0] & m_dl[LDLY-1] & ~m_h;
    end
  end

  // monitor: edges since clear, first-high edge and high/low counts
  bit cmp_en = 0;
  int ed, hi_first, lo_first, hi_ones, hi_zeros, lo_ones;
  task automatic clr_mon();
    ed = 0; hi_first = 0; lo_first = 0; hi_ones = 0; hi_zeros = 0; lo_ones = 0;
  endtask
  always @(posedge clk) begin
    #2;
    ed++;
    if (g_hi) begin hi_ones++; if (hi_first == 0) hi_first = ed; end
    else hi_zeros++;
    if (g_lo) begin lo_ones++; if (lo_first == 0) lo_first = ed; end
    if (cmp_en) begin
      check("R2/R3/R7 random gate_hi", int'(g_hi), int'(m_gh));
      check("R5/R6/R7 random gate_lo", int'(g_lo), int'(m_gl));
      check("R9 exclusive", int'(g_hi & g_lo), 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    c_hi = 1; c_lo = 0;
    cyc(4);
    check("R8 reset gate_hi", int'(g_hi), 0);
    check("R8 reset gate_lo", int'(g_lo), 0);
    c_hi = 0;
    rst_n = 1;
    cyc(20);

    // R2 latency and single-channel enable
    clr_mon(); c_hi = 1; cyc(12);
    check("R2 hi first edge", hi_first, 4);
    check("R2 lo stays off", lo_ones, 0);
    c_hi = 0; cyc(20);

    // R6 low-side latency
    clr_mon(); c_lo = 1; cyc(12);
    check("R6 lo first edge", lo_first, LDLY + 3);
    check("R6 hi stays off", hi_ones, 0);
    c_lo = 0; cyc(20);

    // R4 short on pulse
    clr_mon(); c_hi = 1; cyc(1); c_hi = 0; cyc(20);
    check("R4 short on stretched", hi_ones, MINW);
    // R4 long pulse unchanged
    clr_mon(); c_hi = 1; cyc(8); c_hi = 0; cyc(20);
    check("R4 long pulse kept", hi_ones, 8);
    // R4 short off gap
    c_hi = 1; cyc(20);
    clr_mon(); c_hi = 0; cyc(1); c_hi = 1; cyc(20);
    check("R4 short gap stretched", hi_zeros, MINW);
    c_hi = 0; cyc(20);

    // R5 low side short pulse passes
    clr_mon(); c_lo = 1; cyc(1); c_lo = 0; cyc(20);
    check("R5 lo pulse 1 cycle", lo_ones, 1);

    // R3 interlock
    c_hi = 1; cyc(20); c_lo = 1; cyc(20);
    clr_mon(); cyc(5);
    check("R3 both cmd hi off", hi_ones, 0);
    check("R3 both cmd lo off", lo_ones, 0);
    c_lo = 0; cyc(20);
    check("R3 hi resumes", int'(g_hi), 1);
    c_hi = 0; cyc(20);

    // R1 shutdown
    c_lo = 1; cyc(20);
    check("R1 lo on before sd", int'(g_lo), 1);
    clr_mon(); sd_n = 0; cyc(1);
    cyc(1);
    check("R1 lo still on 2 edges", int'(g_lo), 1);
    cyc(1);
    check("R1 lo off 3rd edge", int'(g_lo), 0);
    c_hi = 1; c_lo = 0; cyc(20);
    check("R1 hi held off", int'(g_hi), 0);
    sd_n = 1; cyc(20);
    check("R1 hi after release", int'(g_hi), 1);

    // R7 supply gating, per side
    uvh = 0; cyc(10);
    check("R7 uv hi forces off", int'(g_hi), 0);
    uvh = 1; c_hi = 0; c_lo = 1; cyc(20);
    uvh = 0; cyc(10);
    check("R7 uv hi leaves lo", int'(g_lo), 1);
    uvh = 1; uvl = 0; cyc(10);
    check("R7 uv lo forces off", int'(g_lo), 0);
    uvl = 1; c_lo = 0; cyc(20);

    // random phase against model
    cmp_en = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(5) == 0) c_hi = ~c_hi;
      if ($urandom_range(5) == 0) c_lo = ~c_lo;
      sd_n = ($urandom_range(39) != 0);
      if ($urandom_range(29) == 0) uvh = ~uvh; else if (!uvh && $urandom_range(3) == 0) uvh = 1;
      if ($urandom_range(29) == 0) uvl = ~uvl; else if (!uvl && $urandom_range(3) == 0) uvl = 1;
      cyc(1);
    end
    cmp_en = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule